// File: doc/BRIEF.md
# Daisy-Chained Interrupt Request Sequencer

This block is the interrupt logic that sits in one device controller on a byte-wide I/O bus. Several controllers are linked by a hard-wired priority chain, and each controller passes priority to the next one down. A four-state sequencer (disarmed, armed, wait, active) decides three things: when the controller may raise its active-low interrupt request, when it withholds priority from lower controllers, and whether it blocks the select chain during an acknowledge.

Software arms the sequencer with an arm command. A concurrent I/O request arms it too. Once armed, the sequencer enters wait when the device is ready and the controller holds priority from above. It then stays in wait until the processor acknowledges. An acknowledge is an I/O control register state of 5. When the acknowledge arrives together with select-in, the controller places its 6-bit vector on the shared input data byte and moves to active. In active it keeps priority from lower controllers until software rearms or disarms it, or until a concurrent I/O request arrives. All bus lines are active-low.

Top module: `irq_chain_seq`

## Requirements
- R1: While reset is low, and after it is released, the sequencer is disarmed. irq_n and sel_out_n are high, data_n is 8'hFF, data_oe is 0, and pri_out_n follows pri_in_n. Reset takes effect at once and is released on the second rising clock edge after rst_n goes high.
- R2: seq_state reports the sequencer state as a 2-bit code: 2'b00 disarmed, 2'b01 armed, 2'b11 wait, 2'b10 active.
- R3: arm_cmd or cio_req moves the sequencer to armed at the next edge from disarmed, armed or active. In wait, both are ignored.
- R4: disarm_cmd moves the sequencer to disarmed at the next edge from any state. It takes precedence over arm_cmd and cio_req in the same cycle.
- R5: From armed, the sequencer enters wait at the next edge only if dev_ready is 1 and pri_in_n is 0. With pri_in_n high it stays armed. While disarmed, dev_ready has no effect.
- R6: irq_n is low exactly while the state is wait.
- R7: pri_out_n equals pri_in_n in disarmed and armed. It is held high in wait and in active.
- R8: An acknowledge is present when ioc_state equals 3'd5. During an acknowledge, sel_out_n equals sel_in_n in every state except wait, where it is held high. Without an acknowledge, sel_out_n is high.
- R9: In wait, when an acknowledge is present and sel_in_n is low, in that same cycle data_oe is 1 and data_n carries bit 7 = 1, bits 6..1 = ~vec_id, and bit 0 = 1. At the next edge the state becomes active and irq_n returns high. At all other times data_oe is 0 and data_n is 8'hFF.
- R10: From active, arm_cmd or cio_req leads to armed and disarm_cmd leads to disarmed. Either way pri_out_n again follows pri_in_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_cmd | input | 1 | Arm command strobe from software |
| disarm_cmd | input | 1 | Disarm command strobe from software |
| cio_req | input | 1 | Concurrent I/O request strobe |
| dev_ready | input | 1 | Device wants to interrupt (sampled at the clock) |
| pri_in_n | input | 1 | Priority from the higher controller, active-low |
| sel_in_n | input | 1 | Select from the higher controller, active-low |
| ioc_state | input | 3 | I/O control register state; 5 means acknowledge |
| vec_id | input | 6 | This controller's interrupt vector |
| irq_n | output | 1 | Interrupt request to the processor, active-low |
| pri_out_n | output | 1 | Priority to the lower controller, active-low |
| sel_out_n | output | 1 | Select to the lower controller, active-low |
| data_n | output | 8 | Input data byte value, active-low |
| data_oe | output | 1 | Drive enable for data_n |
| seq_state | output | 2 | Current sequencer state code |

## Verification
The chain outputs (pri_out_n, sel_out_n, data_n, data_oe) are combinational and are due in the same cycle as the input that drives them. State changes, and irq_n with them, become visible one rising edge after the command or condition. The bench changes its inputs on the falling edge and samples 2 ns later, well before the next rising edge. Each vector row therefore checks its own combinational outputs against the state left by the previous row. The reset test checks the outputs right after rst_n falls, because reset is asynchronous. After release it waits more than the two-edge release delay.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Gray-ordered walk: idle -> armed -> wait -> active
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'b00,
    SEQ_ARMED  = 2'b01,
    SEQ_WAIT   = 2'b11,
    SEQ_ACTIVE = 2'b10
  } seq_state_e;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_cmd,
  input  logic       disarm_cmd,
  input  logic       cio_req,
  input  logic       dev_ready,
  input  logic       pri_granted,
  input  logic       ack_sel,
  output seq_state_e st_q
);

  seq_state_e st_d;
  logic       st_en;

  // next-state process
  always_comb begin
    st_d = st_q;
    if (disarm_cmd) begin
      st_d = SEQ_IDLE;
    end else begin
      unique case (st_q)
        SEQ_IDLE, SEQ_ACTIVE: if (arm_cmd || cio_req) st_d = SEQ_ARMED;
        SEQ_ARMED:            if (dev_ready && pri_granted) st_d = SEQ_WAIT;
        SEQ_WAIT:             if (ack_sel) st_d = SEQ_ACTIVE;
        default:              st_d = SEQ_IDLE;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SEQ_IDLE;
    else if (st_en) st_q <= st_d;
  end

  // R4: disarm always lands in idle
  a_r4_disarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_cmd |=> st_q == SEQ_IDLE);

  // R5: no request without priority
  a_r5_needs_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ARMED && !pri_granted) |=> st_q != SEQ_WAIT);

  // R9: acknowledged with select moves to active
  a_r9_ack_to_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WAIT && ack_sel && !disarm_cmd) |=> st_q == SEQ_ACTIVE);

  // R3: wait ignores arm and concurrent requests
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WAIT && !ack_sel && !disarm_cmd) |=> st_q == SEQ_WAIT);

endmodule

// File: rtl/irq_seq_chain.sv
module irq_seq_chain
  import irq_seq_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int VEC_W    = 6,
  parameter int VEC_LSB  = 1,
  parameter int CTL_W    = 3,
  parameter int ACK_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       st,
  input  logic             pri_in_n,
  input  logic             sel_in_n,
  input  logic [CTL_W-1:0] ioc_state,
  input  logic [VEC_W-1:0] vec_id,
  output logic             pri_granted,
  output logic             ack_sel,
  output logic             irq_n,
  output logic             pri_out_n,
  output logic             sel_out_n,
  output logic [BUS_W-1:0] data_n,
  output logic             data_oe
);

  localparam int VEC_MSB = VEC_LSB + VEC_W - 1;

  logic ack;
  logic requesting;
  logic holds_pri;
  logic [BUS_W-1:0] vec_byte_n;

  assign ack         = (ioc_state == CTL_W'(ACK_CODE));
  assign requesting  = (st == SEQ_WAIT);
  assign holds_pri   = (st == SEQ_WAIT) || (st == SEQ_ACTIVE);
  assign pri_granted = !pri_in_n;
  assign ack_sel     = ack && !sel_in_n;

  assign irq_n     = !requesting;
  assign pri_out_n = holds_pri ? 1'b1 : pri_in_n;
  assign sel_out_n = (ack && !requesting) ? sel_in_n : 1'b1;

  // vector bits inverted onto the low-true bus, others idle high
  for (genvar b = 0; b < BUS_W; b++) begin : g_byte
    if (b >= VEC_LSB && b <= VEC_MSB) begin : g_vec
      assign vec_byte_n[b] = ~vec_id[b-VEC_LSB];
    end else begin : g_pad
      assign vec_byte_n[b] = 1'b1;
    end
  end

  assign data_oe = requesting && ack_sel;
  assign data_n  = data_oe ? vec_byte_n : {BUS_W{1'b1}};

  // R7: priority withheld while requesting or active
  a_r7_pri_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_WAIT || st == SEQ_ACTIVE) |-> pri_out_n);

  // R8: a requester blocks the select chain
  a_r8_sel_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_WAIT) |-> sel_out_n);

  // R9: drive only while requesting, pad bits idle high
  a_r9_drive_pads: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (irq_n == 1'b0 && data_n[0] && data_n[BUS_W-1]));

  // R6: request line low only in wait
  a_r6_irq_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (st == SEQ_WAIT && pri_out_n));

endmodule

// File: rtl/irq_chain_seq.sv
module irq_chain_seq
  import irq_seq_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int VEC_W    = 6,
  parameter int VEC_LSB  = 1,
  parameter int CTL_W    = 3,
  parameter int ACK_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_cmd,
  input  logic             disarm_cmd,
  input  logic             cio_req,
  input  logic             dev_ready,
  input  logic             pri_in_n,
  input  logic             sel_in_n,
  input  logic [CTL_W-1:0] ioc_state,
  input  logic [VEC_W-1:0] vec_id,
  output logic             irq_n,
  output logic             pri_out_n,
  output logic             sel_out_n,
  output logic [BUS_W-1:0] data_n,
  output logic             data_oe,
  output logic [1:0]       seq_state
);

  logic [1:0] rst_sync;
  logic       rst_q_n;
  seq_state_e st;
  logic       pri_granted;
  logic       ack_sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  irq_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .arm_cmd     (arm_cmd),
    .disarm_cmd  (disarm_cmd),
    .cio_req     (cio_req),
    .dev_ready   (dev_ready),
    .pri_granted (pri_granted),
    .ack_sel     (ack_sel),
    .st_q        (st)
  );

  irq_seq_chain #(
    .BUS_W    (BUS_W),
    .VEC_W    (VEC_W),
    .VEC_LSB  (VEC_LSB),
    .CTL_W    (CTL_W),
    .ACK_CODE (ACK_CODE)
  ) u_chain (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .st          (st),
    .pri_in_n    (pri_in_n),
    .sel_in_n    (sel_in_n),
    .ioc_state   (ioc_state),
    .vec_id      (vec_id),
    .pri_granted (pri_granted),
    .ack_sel     (ack_sel),
    .irq_n       (irq_n),
    .pri_out_n   (pri_out_n),
    .sel_out_n   (sel_out_n),
    .data_n      (data_n),
    .data_oe     (data_oe)
  );

  assign seq_state = st;

endmodule

// File: tb/irq_chain_seq_test.sv
module irq_chain_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arm_cmd, disarm_cmd, cio_req, dev_ready;
  logic       pri_in_n, sel_in_n;
  logic [2:0] ioc_state;
  logic [5:0] vec_id;
  logic       irq_n, pri_out_n, sel_out_n, data_oe;
  logic [7:0] data_n;
  logic [1:0] seq_state;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_chain_seq uut (
    .clk(clk), .rst_n(rst_n), .arm_cmd(arm_cmd), .disarm_cmd(disarm_cmd),
    .cio_req(cio_req), .dev_ready(dev_ready), .pri_in_n(pri_in_n),
    .sel_in_n(sel_in_n), .ioc_state(ioc_state), .vec_id(vec_id),
    .irq_n(irq_n), .pri_out_n(pri_out_n), .sel_out_n(sel_out_n),
    .data_n(data_n), .data_oe(data_oe), .seq_state(seq_state)
  );

  typedef struct packed {
    logic       arm, dis, cio, rdy, pri_n, sel_n;
    logic [2:0] ioc;
    logic [1:0] st;
    logic       irq, pri, sel, oe;
    logic [7:0] dat;
  } row_t;

  // expected values are the outputs seen before the edge that applies the row
  localparam int NROWS = 31;
  localparam row_t TBL [NROWS] = '{
    '{0,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF}, // R1 idle after reset
    '{0,0,0,1,0,1,3'd0, 2'b00,1,0,1,0,8'hFF}, // R5 ready ignored while disarmed
    '{0,0,0,0,1,1,3'd0, 2'b00,1,1,1,0,8'hFF}, // R7 pass-through high
    '{1,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF}, // R3 arm
    '{0,0,0,1,1,1,3'd0, 2'b01,1,1,1,0,8'hFF}, // R5 ready without priority
    '{0,0,0,0,1,0,3'd5, 2'b01,1,1,0,0,8'hFF}, // R8 armed passes select
    '{0,0,0,1,0,1,3'd0, 2'b01,1,0,1,0,8'hFF}, // R5 ready with priority
    '{0,0,0,0,0,1,3'd0, 2'b11,0,1,1,0,8'hFF}, // R6 request low in wait
    '{1,0,1,0,0,1,3'd0, 2'b11,0,1,1,0,8'hFF}, // R3 arm and cio ignored in wait
    '{0,0,0,0,0,1,3'd5, 2'b11,0,1,1,0,8'hFF}, // R9 ack without select
    '{0,0,0,0,0,0,3'd4, 2'b11,0,1,1,0,8'hFF}, // R8 code 4 is no ack
    '{0,0,0,0,0,0,3'd6, 2'b11,0,1,1,0,8'hFF}, // R8 code 6 is no ack
    '{0,0,0,0,0,0,3'd5, 2'b11,0,1,1,1,8'hAB}, // R9 vector driven
    '{0,0,0,0,0,1,3'd0, 2'b10,1,1,1,0,8'hFF}, // R9 active, request released
    '{0,0,0,0,0,0,3'd5, 2'b10,1,1,0,0,8'hFF}, // R8 active passes select
    '{0,0,1,0,0,1,3'd0, 2'b10,1,1,1,0,8'hFF}, // R10 cio leaves active
    '{0,0,0,0,0,1,3'd0, 2'b01,1,0,1,0,8'hFF}, // R10 priority restored
    '{0,0,0,1,0,1,3'd0, 2'b01,1,0,1,0,8'hFF},
    '{1,1,0,0,0,1,3'd0, 2'b11,0,1,1,0,8'hFF}, // R4 disarm beats arm in wait
    '{0,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF},
    '{0,0,1,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF}, // R3 cio arms
    '{0,0,0,1,0,1,3'd0, 2'b01,1,0,1,0,8'hFF},
    '{0,0,0,0,0,0,3'd5, 2'b11,0,1,1,1,8'hAB},
    '{1,1,0,0,0,1,3'd0, 2'b10,1,1,1,0,8'hFF}, // R4 disarm beats arm in active
    '{1,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF},
    '{0,0,0,1,0,1,3'd0, 2'b01,1,0,1,0,8'hFF},
    '{0,0,0,0,0,0,3'd5, 2'b11,0,1,1,1,8'hAB},
    '{1,0,0,0,0,1,3'd0, 2'b10,1,1,1,0,8'hFF}, // R10 rearm from active
    '{0,0,0,0,0,1,3'd0, 2'b01,1,0,1,0,8'hFF},
    '{0,1,0,0,0,1,3'd0, 2'b01,1,0,1,0,8'hFF}, // R4 disarm from armed
    '{0,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF}  // R2 back to code 00
  };

  task automatic drive(input row_t r);
    arm_cmd = r.arm; disarm_cmd = r.dis; cio_req = r.cio; dev_ready = r.rdy;
    pri_in_n = r.pri_n; sel_in_n = r.sel_n; ioc_state = r.ioc;
  endtask

  task automatic check(input string tag, input row_t r);
    bit bad = 1'b0;
    checks++;
    if (seq_state !== r.st) begin
      $display("FAIL %s R2 state: got %b exp %b", tag, seq_state, r.st); bad = 1'b1;
    end
    if (irq_n !== r.irq) begin
      $display("FAIL %s R6 irq_n: got %b exp %b", tag, irq_n, r.irq); bad = 1'b1;
    end
    if (pri_out_n !== r.pri) begin
      $display("FAIL %s R7 pri_out_n: got %b exp %b", tag, pri_out_n, r.pri); bad = 1'b1;
    end
    if (sel_out_n !== r.sel) begin
      $display("FAIL %s R8 sel_out_n: got %b exp %b", tag, sel_out_n, r.sel); bad = 1'b1;
    end
    if (data_oe !== r.oe || data_n !== r.dat) begin
      $display("FAIL %s R9 data: got oe=%b %h exp oe=%b %h", tag, data_oe, data_n, r.oe, r.dat);
      bad = 1'b1;
    end
    if (bad) errors++;
  endtask

  task automatic step(input string tag, input row_t r);
    @(negedge clk);
    drive(r);
    #2;
    check(tag, r);
  endtask

  initial begin
    row_t idle = '{0,0,0,0,0,1,3'd0, 2'b00,1,0,1,0,8'hFF};
    row_t r;
    rst_n = 1'b0;
    vec_id = 6'h2A;
    drive(idle);
    #3;
    check("R1 in reset", idle);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      step($sformatf("row%0d", i), TBL[i]);
    end

    // R1: asynchronous reset from wait
    r = idle; r.arm = 1'b1;             step("R1 setup arm", r);
    r = idle; r.rdy = 1'b1; r.st = 2'b01; step("R1 setup ready", r);
    r = idle; r.st = 2'b11; r.irq = 1'b0; r.pri = 1'b1; step("R1 setup wait", r);
    #3;
    rst_n = 1'b0;
    #2;
    check("R1 async reset", idle);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R1 after release", idle);

    // R9: vector 6'h3F -> 8'h81
    vec_id = 6'h3F;
    r = idle; r.cio = 1'b1;             step("R9 setup cio", r);
    r = idle; r.rdy = 1'b1; r.st = 2'b01; step("R9 setup ready", r);
    r = idle; r.sel_n = 1'b0; r.ioc = 3'd5; r.st = 2'b11; r.irq = 1'b0; r.pri = 1'b1;
    r.oe = 1'b1; r.dat = 8'h81;         step("R9 vector 3F", r);
    r = idle; r.st = 2'b10; r.pri = 1'b1; step("R9 active after ack", r);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule